// File: doc/BRIEF.md
# Dual-Port Two-Word Burst SRAM Sequencer

This block is a synthesizable behavioural model of a synchronous static memory with a separate read port and write port. Every access moves exactly two words. A port starts a burst when its active-low select is found low while the port is idle. At that edge the port captures the shared address bus. The captured address is widened by one internal low bit, which selects the even word first and the odd word second. A small internal array holds the data.

The read machine and the write machine are two copies of one burst controller and run side by side. In any cycle one may start, continue or rest without regard to the other. Read words come back on `rd_data` a fixed number of clock edges after the read is sampled, and `rd_valid` marks both beats. Write words are taken from `wr_data` on the sampling edge and on the edge after it. Each beat has its own per-byte write mask. The clock pair of the physical interface is modelled as one clock, with one beat on each rising edge.

Top module: `dp_burst_sram`

## Requirements
- R1: After reset is released, both ports spend one clock in an initial state. Select levels sampled at that first edge start nothing.
- R2: A read sampled at idle with address A produces `rd_valid` high for exactly two consecutive cycles. The first cycle carries word 2A and the second carries word 2A+1. The first beat appears after the RD_LAT-th rising edge, counting the sampling edge as the first.
- R3: A write sampled at idle with address A stores the `wr_data` present at the sampling edge into word 2A. It stores the `wr_data` present at the next edge into word 2A+1.
- R4: Bit b of `wr_be` enables bits 8b+7..8b on each write beat independently. Masked bytes keep their old content.
- R5: The burst order is always the even word and then the odd word, with no wrap. The address bus is ignored on the second beat of a burst.
- R6: A select is ignored on the second beat of an active burst. A started burst always completes both beats, and a low select on its second beat does not restart it.
- R7: If a select is low on the edge right after a burst's second beat, a new burst starts at that edge with no idle cycle.
- R8: If a select is high while its port is idle, the port stays idle. No read beat is produced and no word is written.
- R9: Read and write bursts proceed concurrently and independently, each with its own phase.
- R10: When a read and a write touch the same word on the same edge, the read returns the content from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one burst beat per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_sel_n | input | 1 | Active-low read select |
| wr_sel_n | input | 1 | Active-low write select |
| addr | input | ADDR_W (4) | Shared burst base address |
| wr_data | input | DATA_W (16) | Write data for the current beat |
| wr_be | input | DATA_W/8 (2) | Per-byte write enable for the current beat |
| rd_data | output | DATA_W (16) | Read data beat |
| rd_valid | output | 1 | High while rd_data carries a read beat |

## Verification
A controller stuck in the wrong phase shows up on the outputs within one burst. Either `rd_valid` comes out in runs of odd length, or the beats come out in the wrong order (odd word first, or the same word twice). A lost phase in the write machine does not show at once. It becomes visible only when the affected words are read back. For that reason the random phase interleaves reads closely with writes, so a bad write surfaces within a few dozen cycles. A wrong read-versus-write ordering on the array shows only when both ports hit the same word on the same edge, and directed collision cases cover that.

// File: rtl/dpb_pkg.sv
// Shared types for the dual-port burst memory.
// Assumes: one beat per rising clock edge.
package dpb_pkg;
    // Phase of one burst port.
    typedef enum logic [1:0] {
        PH_INIT   = 2'd0,
        PH_IDLE   = 2'd1,
        PH_SECOND = 2'd2
    } phase_t;
endpackage

// File: rtl/dpb_burst_ctrl.sv
// One burst port controller. It samples the active-low select at idle,
// latches the base address and issues an even-word beat, then an odd-word beat.
// Assumes: the select and the address are only meaningful at a start slot.
module dpb_burst_ctrl
    import dpb_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int IDX_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              go,
    output logic              first,
    output logic [IDX_W-1:0]  idx
);
    phase_t            phase;
    logic [ADDR_W-1:0] base;

    // Start slot: idle with the select low.
    assign first = (phase == PH_IDLE) && !sel_n;
    assign go    = first || (phase == PH_SECOND);
    assign idx   = first ? {addr_in, 1'b0} : {base, 1'b1};

    // Phase sequencing and base-address capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_INIT;
            base  <= '0;
        end else begin
            unique case (phase)
                PH_INIT:   phase <= PH_IDLE;
                PH_IDLE:   if (!sel_n) begin
                               phase <= PH_SECOND;
                               base  <= addr_in;
                           end
                PH_SECOND: phase <= PH_IDLE;
                default:   phase <= PH_INIT;
            endcase
        end
    end
endmodule

// File: rtl/dpb_array.sv
// Storage array with a byte-masked write port and a registered read port.
// Assumes: a read and a write at the same edge and word return the old word.
module dpb_array #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    localparam int IDX_W = ADDR_W + 1,
    localparam int DEPTH = 1 << IDX_W,
    localparam int BYTES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rd_go,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              wr_go,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BYTES-1:0]  wr_be,
    output logic [DATA_W-1:0] rd_word
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] merged;

    // Merge the enabled bytes over the stored word.
    for (genvar b = 0; b < BYTES; b++) begin : g_merge
        assign merged[b*8 +: 8] = wr_be[b] ? wr_data[b*8 +: 8] : mem[wr_idx][b*8 +: 8];
    end

    // Write the merged word.
    always_ff @(posedge clk) begin
        if (wr_go) mem[wr_idx] <= merged;
    end

    // Register the read word; nonblocking order gives read-before-write.
    always_ff @(posedge clk) begin
        if (rd_go) rd_word <= mem[rd_idx];
    end
endmodule

// File: rtl/dpb_rd_pipe.sv
// Delay line for read beats. STAGES extra register stages follow the array register.
// Assumes: STAGES >= 0.
module dpb_rd_pipe #(
    parameter int DATA_W = 16,
    parameter int STAGES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_v,
    input  logic [DATA_W-1:0] in_d,
    output logic              out_v,
    output logic [DATA_W-1:0] out_d
);
    if (STAGES == 0) begin : g_direct
        assign out_v = in_v;
        assign out_d = in_d;
    end else begin : g_stages
        logic              v_q [STAGES];
        logic [DATA_W-1:0] d_q [STAGES];

        // Shift beats and their valid flags along the stages.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < STAGES; i++) begin
                    v_q[i] <= 1'b0;
                    d_q[i] <= '0;
                end
            end else begin
                v_q[0] <= in_v;
                d_q[0] <= in_d;
                for (int i = 1; i < STAGES; i++) begin
                    v_q[i] <= v_q[i-1];
                    d_q[i] <= d_q[i-1];
                end
            end
        end

        assign out_v = v_q[STAGES-1];
        assign out_d = d_q[STAGES-1];
    end
endmodule

// File: rtl/dp_burst_sram.sv
// Top: independent read and write two-word burst ports over one array.
// Assumes: RD_LAT >= 1; DATA_W is a multiple of 8.
module dp_burst_sram #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int RD_LAT = 2,
    localparam int IDX_W = ADDR_W + 1,
    localparam int BYTES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_sel_n,
    input  logic              wr_sel_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BYTES-1:0]  wr_be,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic             rd_go, rd_first, wr_go, wr_first;
    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic [DATA_W-1:0] rd_word;
    logic             rd_v0;

    dpb_burst_ctrl #(.ADDR_W(ADDR_W)) u_rd_ctrl (
        .clk(clk), .rst_n(rst_n), .sel_n(rd_sel_n), .addr_in(addr),
        .go(rd_go), .first(rd_first), .idx(rd_idx)
    );

    dpb_burst_ctrl #(.ADDR_W(ADDR_W)) u_wr_ctrl (
        .clk(clk), .rst_n(rst_n), .sel_n(wr_sel_n), .addr_in(addr),
        .go(wr_go), .first(wr_first), .idx(wr_idx)
    );

    dpb_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rd_go(rd_go), .rd_idx(rd_idx), .wr_go(wr_go),
        .wr_idx(wr_idx), .wr_data(wr_data), .wr_be(wr_be), .rd_word(rd_word)
    );

    // Valid flag aligned with the array's read register.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_v0 <= 1'b0;
        else        rd_v0 <= rd_go;
    end

    dpb_rd_pipe #(.DATA_W(DATA_W), .STAGES(RD_LAT - 1)) u_pipe (
        .clk(clk), .rst_n(rst_n), .in_v(rd_v0), .in_d(rd_word),
        .out_v(rd_valid), .out_d(rd_data)
    );
endmodule

// File: rtl/dpb_sram_chk.sv
// Protocol checker for dp_burst_sram, attached with bind.
// Assumes: synchronous active-low reset.
module dpb_sram_chk #(
    parameter int ADDR_W = 4,
    localparam int IDX_W = ADDR_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_sel_n,
    input logic             wr_sel_n,
    input logic             rd_go,
    input logic             rd_first,
    input logic [IDX_W-1:0] rd_idx,
    input logic             wr_go,
    input logic             wr_first,
    input logic [IDX_W-1:0] wr_idx,
    input logic             rd_valid
);
    logic after_rst;
    logic vpar;

    // Marks every cycle after the first one out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) after_rst <= 1'b0;
        else        after_rst <= 1'b1;
    end

    // Parity of the number of read beats delivered so far.
    always_ff @(posedge clk) begin
        if (!rst_n)        vpar <= 1'b0;
        else if (rd_valid) vpar <= ~vpar;
    end

    p_init_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !after_rst |-> (!rd_go && !wr_go));

    p_valid_pairs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_valid && $past(rd_valid)) |-> !vpar);

    // R6: the second beat follows whatever the select does.
    p_rd_seq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && rd_first) |=> (rd_go && !rd_first && rd_idx == {$past(rd_idx[IDX_W-1:1]), 1'b1}));

    p_wr_seq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && wr_first) |=> (wr_go && !wr_first && wr_idx == {$past(wr_idx[IDX_W-1:1]), 1'b1}));

    // R8 covered too: a high select after a burst leaves the port idle.
    p_rd_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && !rd_first) |=> (rd_sel_n ? !rd_go : (rd_go && rd_first)));

    p_wr_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && !wr_first) |=> (wr_sel_n ? !wr_go : (wr_go && wr_first)));
endmodule

bind dp_burst_sram dpb_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
    .rd_go(rd_go), .rd_first(rd_first), .rd_idx(rd_idx),
    .wr_go(wr_go), .wr_first(wr_first), .wr_idx(wr_idx), .rd_valid(rd_valid)
);

// File: tb/tb_dp_burst_sram.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// compared with a cycle model built from the requirements.
module tb_dp_burst_sram;
    localparam int AW    = 4;
    localparam int DW    = 16;
    localparam int NB    = DW / 8;
    localparam int LAT   = 2;
    localparam int DEPTH = 1 << (AW + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_sel_n = 1'b1, wr_sel_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [NB-1:0] wr_be = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // Model state
    logic [DW-1:0] m_mem [DEPTH];
    int            m_rph = 0, m_wph = 0, m_rb = 0, m_wb = 0;
    bit            ev [LAT];
    logic [DW-1:0] ed [LAT];

    dp_burst_sram #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
        .addr(addr), .wr_data(wr_data), .wr_be(wr_be),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always #10 clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // Expected effect of one rising edge (R1, R2, R3, R4, R5, R6, R7, R8, R10).
    task automatic model_edge(bit rs, bit ws, int a, logic [DW-1:0] d, logic [NB-1:0] be);
        bit rgo, wgo;
        int ridx, widx;
        logic [DW-1:0] rv;
        rgo = 0; wgo = 0; ridx = 0; widx = 0;
        case (m_rph)
            0: m_rph = 1;
            1: if (!rs) begin rgo = 1; ridx = a * 2; m_rb = a; m_rph = 2; end
            default: begin rgo = 1; ridx = m_rb * 2 + 1; m_rph = 1; end
        endcase
        case (m_wph)
            0: m_wph = 1;
            1: if (!ws) begin wgo = 1; widx = a * 2; m_wb = a; m_wph = 2; end
            default: begin wgo = 1; widx = m_wb * 2 + 1; m_wph = 1; end
        endcase
        rv = m_mem[ridx];
        if (wgo)
            for (int b = 0; b < NB; b++)
                if (be[b]) m_mem[widx][b*8 +: 8] = d[b*8 +: 8];
        for (int i = LAT - 1; i > 0; i--) begin
            ev[i] = ev[i-1];
            ed[i] = ed[i-1];
        end
        ev[0] = rgo;
        ed[0] = rv;
    endtask

    // Drive one cycle at the falling edge, advance, and check at the next falling edge.
    task automatic step(string tag, bit rs, bit ws, int a, logic [DW-1:0] d, logic [NB-1:0] be);
        rd_sel_n = rs; wr_sel_n = ws; addr = a[AW-1:0]; wr_data = d; wr_be = be;
        model_edge(rs, ws, a, d, be);
        @(posedge clk);
        @(negedge clk);
        chk(tag, {31'd0, rd_valid}, {31'd0, ev[LAT-1]});
        if (ev[LAT-1]) chk(tag, {16'd0, rd_data}, {16'd0, ed[LAT-1]});
    endtask

    task automatic idle(string tag, int n);
        for (int i = 0; i < n; i++) step(tag, 1, 1, $urandom % 16, $urandom, $urandom);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL R2: watchdog actual running expected finished");
        summary();
    end

    initial begin
        void'($urandom(32'h5eed));
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        for (int i = 0; i < LAT; i++) begin ev[i] = 0; ed[i] = '0; end
        rd_sel_n = 1'b0; wr_sel_n = 1'b0; addr = 4'd3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset valid", {31'd0, rd_valid}, 32'd0);
        // R1: selects low on the first edge start nothing.
        step("R1", 0, 0, 3, 16'h1234, 2'b11);
        idle("R1", 3);
        // R7 and R3: fill every word with back-to-back writes; second-beat address is junk (R5).
        for (int i = 0; i < DEPTH; i++)
            step("R7", 1, 0, (i % 2 == 0) ? i / 2 : $urandom % 16, $urandom, 2'b11);
        idle("R8", 4);
        // R2: single read burst.
        step("R2", 0, 1, 5, 0, 0);
        step("R2", 1, 1, 9, 0, 0);
        idle("R2", 3);
        // R5: top address, junk on second beat; no wrap.
        step("R5", 0, 1, 15, 0, 0);
        step("R5", 1, 1, 0, 0, 0);
        idle("R5", 3);
        // R3: write then read back.
        step("R3", 1, 0, 4, 16'hA1B2, 2'b11);
        step("R3", 1, 1, 11, 16'hC3D4, 2'b11);
        step("R3", 0, 1, 4, 0, 0);
        idle("R3", 4);
        // R4: per-beat byte masks.
        step("R4", 1, 0, 9, 16'h55AA, 2'b01);
        step("R4", 1, 1, 9, 16'h6699, 2'b10);
        step("R4", 0, 1, 9, 0, 0);
        idle("R4", 4);
        // R6: select low on the second beat with another address does not restart.
        step("R6", 0, 0, 2, 16'h0F0F, 2'b11);
        step("R6", 0, 0, 7, 16'hF0F0, 2'b11);
        step("R6", 1, 1, 7, 0, 0);
        idle("R6", 3);
        step("R6", 0, 1, 7, 0, 0);
        step("R6", 1, 1, 2, 0, 0);
        step("R6", 0, 1, 2, 0, 0);
        idle("R6", 4);
        // R7: back-to-back reads.
        for (int i = 0; i < 8; i++) step("R7", 0, 1, $urandom % 16, 0, 0);
        idle("R7", 3);
        // R10: same word, same edge.
        step("R10", 0, 0, 6, 16'hBEEF, 2'b11);
        step("R10", 1, 1, 6, 16'hCAFE, 2'b11);
        step("R10", 0, 1, 6, 0, 0);
        idle("R10", 4);
        // R9: random concurrent traffic.
        for (int i = 0; i < 3000; i++)
            step("R9", ($urandom % 3) == 0, ($urandom % 3) == 0, $urandom % 16, $urandom, $urandom);
        idle("R9", 4);
        summary();
    end
endmodule